// File: doc/BRIEF.md
# Wake Event Collector with Power-Management Event Output

This block watches twelve general-purpose input pins, split into a group of eight and a group of four, for wake events. A wake event is a rising edge seen after each pin has passed through a multi-flop synchronizer. Every event latches a per-pin wake flag. Each flag latches whatever the state of any enable. A per-pin mask picks which latched flags raise a single global event flag. A global enable bit then decides whether that flag drives the active-low event output `pme_n`. The output comes from a flop, so it cannot glitch.

Software reaches the block through a small byte-wide register port. The port has a write strobe, a 4-bit offset, write data and combinational read data. All status flags are write-1-to-clear. If a clear and a new event hit the same flag in the same cycle, the event wins.

The block has two reset inputs:
- The standby-power reset `sb_rst_n` clears every register.
- The main-power reset `main_rst_n` leaves every register as it is. While it is low, the register port ignores writes, but wake events are still captured.

Top module: `wake_evt_ctrl`

## Requirements
- R1: While `sb_rst_n` is low, every register reads 0x00 and `pme_n` is 1, and after release they stay so until an event or a write changes them.
- R2: A 0-to-1 change on a pin sets its wake flag a few cycles later, even with its mask bit and the global enable clear. Pin `gp1_pin[i]` sets bit i of offset 0x08, and pin `gp2_pin[j]` sets bit j (bits 3:0) of offset 0x09. A pin that stays high after its flag is cleared does not set it again, and a 1-to-0 change sets nothing.
- R3: Writing a 1 to a bit of offset 0x08 or 0x09 clears that wake flag. A 0 bit in the written byte leaves that flag unchanged.
- R4: If a write-1-to-clear and a new wake event reach the same wake flag in the same cycle, the flag ends up at 1.
- R5: Bit 0 of offset 0x00 (global event flag) sets when some wake flag is 1 and its mask bit is 1, whatever the global enable. Mask bits live at offset 0x0A (bit i for `gp1_pin[i]`) and 0x0B bits 3:0 (bit j for `gp2_pin[j]`). The flag is not set by unmasked wake flags.
- R6: Writing 1 to bit 0 of offset 0x00 clears the global event flag once no masked wake flag is pending, and writing 0 leaves it unchanged.
- R7: Bit 0 of offset 0x04 is the global enable. `pme_n` is 0 exactly one clock after both the global event flag and the enable are 1, and 1 one clock after either is 0.
- R8: Offsets 0x01-0x03 and 0x05-0x07 read 0x00. Bits 7:1 of offsets 0x00 and 0x04 read 0, and so do bits 7:4 of offsets 0x09 and 0x0B, whatever is written there.
- R9: While `main_rst_n` is low, writes through the register port change no register, and wake events are still latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| sb_rst_n | input | 1 | Standby-power reset, active low, asynchronous, clears all state |
| main_rst_n | input | 1 | Main-power reset, active low; blocks register writes, keeps contents |
| bus_we | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| gp1_pin | input | 8 | First wake pin group, asynchronous |
| gp2_pin | input | 4 | Second wake pin group, asynchronous |
| pme_n | output | 1 | Power-management event output, active low, registered |

## Verification
Several pin patterns are driven on both groups:
- A single rising edge separates edge capture from level capture.
- A pin held high after its flag is cleared shows that a level does not set the flag again.
- A falling edge shows that only 0-to-1 changes count.

Unmasked pins, and masked pins with the enable off and then on, show that latching, the global flag and the output gate are three separate levels. A rising edge timed to land in the same clock as a clear of that flag shows the set-priority rule. The cycle in which `pme_n` changes is sampled on both sides of the output flop.

// File: rtl/wk_pkg.sv
package wk_pkg;
   localparam int DATA_W = 8;
   localparam int ADDR_W = 4;

   localparam logic [ADDR_W-1:0] OFS_GSTAT = 4'h0;
   localparam logic [ADDR_W-1:0] OFS_GEN   = 4'h4;
   localparam logic [ADDR_W-1:0] OFS_WAKE1 = 4'h8;
   localparam logic [ADDR_W-1:0] OFS_WAKE2 = 4'h9;
   localparam logic [ADDR_W-1:0] OFS_MASK1 = 4'hA;
   localparam logic [ADDR_W-1:0] OFS_MASK2 = 4'hB;
endpackage

// File: rtl/wk_sync_edge.sv
module wk_sync_edge #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] rise
);
   if (STAGES < 2) begin : g_bad_stages
      $error("wk_sync_edge: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("wk_sync_edge: W must be at least 1");
   end

   logic [W-1:0] stg [STAGES];
   logic [W-1:0] last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= '0;
         last_q <= '0;
      end else begin
         stg[0] <= din;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
         last_q <= stg[STAGES-1];
      end
   end

   assign rise = stg[STAGES-1] & ~last_q;

   // R2: each edge yields a pulse of exactly one cycle per bit
   p_rise_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rise != '0) |=> ((rise & $past(rise)) == '0));
endmodule

// File: rtl/wk_w1c_bank.sv
module wk_w1c_bank #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set,
   input  logic [W-1:0] clr,
   output logic [W-1:0] q
);
   if (W < 1) begin : g_bad_width
      $error("wk_w1c_bank: W must be at least 1");
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q[i] <= 1'b0;
         else        q[i] <= set[i] | (q[i] & ~clr[i]);
      end

      p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
         set[i] |=> q[i]);
      p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (clr[i] && !set[i]) |=> !q[i]);
      p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (!set[i] && !clr[i]) |=> $stable(q[i]));
   end
endmodule

// File: rtl/wake_evt_ctrl.sv
module wake_evt_ctrl
   import wk_pkg::*;
#(
   parameter int N1          = 8,
   parameter int N2          = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              sb_rst_n,
   input  logic              main_rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [N1-1:0]     gp1_pin,
   input  logic [N2-1:0]     gp2_pin,
   output logic              pme_n
);
   if (N1 < 1 || N1 > DATA_W) begin : g_bad_n1
      $error("wake_evt_ctrl: N1 must lie in 1..DATA_W");
   end
   if (N2 < 1 || N2 > DATA_W) begin : g_bad_n2
      $error("wake_evt_ctrl: N2 must lie in 1..DATA_W");
   end

   logic          wr_ok;
   logic [N1-1:0] rise1, clr1, wake1, mask1;
   logic [N2-1:0] rise2, clr2, wake2, mask2;
   logic          gstat, gen, gset, gclr;

   assign wr_ok = bus_we & main_rst_n;

   wk_sync_edge #(.W(N1), .STAGES(SYNC_STAGES)) u_sync1 (
      .clk(clk), .rst_n(sb_rst_n), .din(gp1_pin), .rise(rise1));
   wk_sync_edge #(.W(N2), .STAGES(SYNC_STAGES)) u_sync2 (
      .clk(clk), .rst_n(sb_rst_n), .din(gp2_pin), .rise(rise2));

   assign clr1 = (wr_ok && bus_addr == OFS_WAKE1) ? bus_wdata[N1-1:0] : '0;
   assign clr2 = (wr_ok && bus_addr == OFS_WAKE2) ? bus_wdata[N2-1:0] : '0;

   wk_w1c_bank #(.W(N1)) u_bank1 (
      .clk(clk), .rst_n(sb_rst_n), .set(rise1), .clr(clr1), .q(wake1));
   wk_w1c_bank #(.W(N2)) u_bank2 (
      .clk(clk), .rst_n(sb_rst_n), .set(rise2), .clr(clr2), .q(wake2));

   assign gset = (|(wake1 & mask1)) | (|(wake2 & mask2));
   assign gclr = wr_ok && bus_addr == OFS_GSTAT && bus_wdata[0];

   always_ff @(posedge clk or negedge sb_rst_n) begin
      if (!sb_rst_n) begin
         gstat <= 1'b0;
         gen   <= 1'b0;
         mask1 <= '0;
         mask2 <= '0;
         pme_n <= 1'b1;
      end else begin
         gstat <= gset | (gstat & ~gclr);
         if (wr_ok && bus_addr == OFS_GEN)   gen   <= bus_wdata[0];
         if (wr_ok && bus_addr == OFS_MASK1) mask1 <= bus_wdata[N1-1:0];
         if (wr_ok && bus_addr == OFS_MASK2) mask2 <= bus_wdata[N2-1:0];
         pme_n <= ~(gstat & gen);
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         OFS_GSTAT: bus_rdata[0]      = gstat;
         OFS_GEN:   bus_rdata[0]      = gen;
         OFS_WAKE1: bus_rdata[N1-1:0] = wake1;
         OFS_WAKE2: bus_rdata[N2-1:0] = wake2;
         OFS_MASK1: bus_rdata[N1-1:0] = mask1;
         OFS_MASK2: bus_rdata[N2-1:0] = mask2;
         default:   bus_rdata         = '0;
      endcase
   end

   p_gstat_set_r5: assert property (@(posedge clk) disable iff (!sb_rst_n)
      gset |=> gstat);
   p_gstat_clear_r6: assert property (@(posedge clk) disable iff (!sb_rst_n)
      (gclr && !gset) |=> !gstat);
   p_pme_on_r7: assert property (@(posedge clk) disable iff (!sb_rst_n)
      (gstat && gen) |=> !pme_n);
   p_pme_off_r7: assert property (@(posedge clk) disable iff (!sb_rst_n)
      !(gstat && gen) |=> pme_n);
   p_reserved_zero_r8: assert property (@(posedge clk) disable iff (!sb_rst_n)
      (bus_addr inside {[4'h1:4'h3], [4'h5:4'h7]}) |-> bus_rdata == '0);
   p_hold_in_main_rst_r9: assert property (@(posedge clk) disable iff (!sb_rst_n)
      !main_rst_n |=> ($stable(gen) && $stable(mask1) && $stable(mask2)));
endmodule

// File: tb/sim_wake_evt_ctrl.sv
module sim_wake_evt_ctrl;
   logic       clk = 1'b0;
   logic       sb_rst_n = 1'b0;
   logic       main_rst_n = 1'b1;
   logic       bus_we = 1'b0;
   logic [3:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [7:0] gp1_pin = '0;
   logic [3:0] gp2_pin = '0;
   logic       pme_n;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   wake_evt_ctrl u0 (
      .clk(clk), .sb_rst_n(sb_rst_n), .main_rst_n(main_rst_n),
      .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .gp1_pin(gp1_pin), .gp2_pin(gp2_pin),
      .pme_n(pme_n));

   task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s got=0x%02h expected=0x%02h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd_chk(input string tag, input logic [3:0] a, input logic [7:0] exp);
      bus_addr = a;
      #1;
      chk(tag, bus_rdata, exp);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset;
      chk("R1 pme_n after reset", {7'd0, pme_n}, 8'h01);
      for (int a = 0; a < 12; a++) rd_chk("R1 R8 reset readback", a[3:0], 8'h00);
   endtask

   task automatic t_capture;
      gp1_pin = 8'h08;
      idle(5);
      rd_chk("R2 group1 bit3 latched unmasked", 4'h8, 8'h08);
      rd_chk("R2 group2 untouched", 4'h9, 8'h00);
      rd_chk("R5 unmasked flag leaves global clear", 4'h0, 8'h00);
      chk("R7 pme_n idle", {7'd0, pme_n}, 8'h01);
      gp2_pin = 4'h4;
      idle(5);
      rd_chk("R2 group2 bit2 latched", 4'h9, 8'h04);
   endtask

   task automatic t_w1c;
      wr(4'h8, 8'h00);
      rd_chk("R3 write zero keeps flag", 4'h8, 8'h08);
      wr(4'h8, 8'hF7);
      rd_chk("R3 other ones keep flag", 4'h8, 8'h08);
      wr(4'h8, 8'h08);
      rd_chk("R3 write one clears", 4'h8, 8'h00);
      idle(5);
      rd_chk("R2 steady high no re-set", 4'h8, 8'h00);
      wr(4'h9, 8'h04);
      rd_chk("R3 group2 clear", 4'h9, 8'h00);
      gp1_pin = 8'h00; gp2_pin = 4'h0;
      idle(5);
      rd_chk("R2 falling edge group1", 4'h8, 8'h00);
      rd_chk("R2 falling edge group2", 4'h9, 8'h00);
   endtask

   task automatic t_global;
      wr(4'hA, 8'h08);
      gp1_pin = 8'h08;
      idle(5);
      rd_chk("R5 masked flag sets global, enable off", 4'h0, 8'h01);
      chk("R7 enable off keeps pme_n high", {7'd0, pme_n}, 8'h01);
      wr(4'h4, 8'hFF);
      chk("R7 pme_n not yet low (registered)", {7'd0, pme_n}, 8'h01);
      rd_chk("R8 enable reserved bits", 4'h4, 8'h01);
      @(negedge clk);
      chk("R7 pme_n low one clock later", {7'd0, pme_n}, 8'h00);
      wr(4'h0, 8'h00);
      rd_chk("R6 write zero keeps global", 4'h0, 8'h01);
      wr(4'h0, 8'h01);
      rd_chk("R6 clear with pending masked flag re-sets", 4'h0, 8'h01);
      wr(4'h8, 8'h08);
      wr(4'h0, 8'h01);
      rd_chk("R6 global cleared", 4'h0, 8'h00);
      chk("R7 pme_n still low in clear cycle", {7'd0, pme_n}, 8'h00);
      @(negedge clk);
      chk("R7 pme_n released", {7'd0, pme_n}, 8'h01);
      gp1_pin = 8'h00;
      idle(3);
   endtask

   task automatic t_mask2;
      wr(4'hB, 8'hFF);
      rd_chk("R8 mask2 upper bits", 4'hB, 8'h0F);
      gp2_pin = 4'h1;
      idle(5);
      rd_chk("R2 group2 bit0", 4'h9, 8'h01);
      rd_chk("R5 group2 mask sets global", 4'h0, 8'h01);
      chk("R7 pme_n low via group2", {7'd0, pme_n}, 8'h00);
      wr(4'h9, 8'h01);
      wr(4'h0, 8'h01);
      gp2_pin = 4'h0;
      idle(3);
      chk("R7 pme_n released after group2", {7'd0, pme_n}, 8'h01);
   endtask

   task automatic t_collide;
      gp1_pin = 8'h08;
      idle(5);
      rd_chk("R2 flag before collision", 4'h8, 8'h08);
      gp1_pin = 8'h00;
      idle(3);
      gp1_pin = 8'h08;
      @(negedge clk);
      @(negedge clk);
      wr(4'h8, 8'h08);
      rd_chk("R4 set beats clear", 4'h8, 8'h08);
      wr(4'h8, 8'h08);
      rd_chk("R3 later clear takes effect", 4'h8, 8'h00);
      wr(4'h0, 8'h01);
      rd_chk("R6 global clear after collision", 4'h0, 8'h00);
      gp1_pin = 8'h00;
      idle(3);
   endtask

   task automatic t_main_rst;
      main_rst_n = 1'b0;
      wr(4'h4, 8'h00);
      wr(4'hA, 8'h00);
      rd_chk("R9 enable kept", 4'h4, 8'h01);
      rd_chk("R9 mask kept", 4'hA, 8'h08);
      gp1_pin = 8'h20;
      idle(5);
      rd_chk("R9 capture during main reset", 4'h8, 8'h20);
      wr(4'h8, 8'h20);
      rd_chk("R9 clear ignored", 4'h8, 8'h20);
      main_rst_n = 1'b1;
      gp1_pin = 8'h00;
      idle(2);
   endtask

   task automatic t_sb_reset;
      gp2_pin = 4'h2;
      idle(5);
      rd_chk("R2 state before standby reset", 4'h9, 8'h02);
      gp2_pin = 4'h0;
      sb_rst_n = 1'b0;
      idle(2);
      chk("R1 pme_n in reset", {7'd0, pme_n}, 8'h01);
      sb_rst_n = 1'b1;
      idle(2);
      for (int a = 0; a < 12; a++) rd_chk("R1 standby reset clears", a[3:0], 8'h00);
   endtask

   initial begin
      idle(3);
      sb_rst_n = 1'b1;
      idle(2);
      t_reset();
      t_capture();
      t_w1c();
      t_global();
      t_mask2();
      t_collide();
      t_main_rst();
      t_sb_reset();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule